// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block decides when one half-duplex Ethernet port may start, or start again, a frame after collisions. A requester raises `tx_req` for a pending frame. The controller first waits an interframe gap of `IFG_BITS` bit times against carrier sense, then pulses `tx_go`. The port stays in the transmitting state until the requester lowers `tx_req`, which marks success, or until a collision pulse arrives.

On a collision the controller adds one to a per-frame collision count. It takes a random number of slot times from a free-running LFSR and waits out that backoff. It then runs the gap again and pulses `tx_go` once more. When the count reaches the attempt limit, it pulses `frame_drop` instead. Three mode inputs change this behaviour:
- Aggressive mode keeps every backoff below 8 slots.
- Two-part mode listens to carrier only in the first part of the gap.
- No-drop mode retries for ever.

While the port is sending backpressure jam traffic, a collision skips the backoff and the port retries at once. Bit time comes from a clock-enable divider that the link speed selects.

Top module: `hdx_backoff_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `tx_go` and `frame_drop` are 0, and the controller is idle with a collision count of zero.
- R2: With two-part mode off, `tx_go` pulses for one cycle exactly `IFG_BITS` bit times after the edge that takes in `tx_req` or ends a backoff. Carrier sampled high on any bit tick of the gap restarts the full gap from that tick.
- R3: With two-part mode on, carrier restarts the gap only on the first `IFG_PART1` bit ticks of the gap. Carrier on the later ticks is ignored, and `tx_go` still comes `IFG_BITS` bit times after the last restart.
- R4: With aggressive mode off, the delay from collision n of a frame to the next `tx_go` is k·`SLOT_BITS` + `IFG_BITS` bit times, with k an integer in 0 .. 2^min(n,`BACKOFF_CAP`) − 1.
- R5: With aggressive mode on, the k of R4 lies in 0 .. 7, whatever the collision count.
- R6: With no-drop mode off, the collision that brings the count to `ATTEMPT_LIMIT` (16) makes `frame_drop` pulse for one cycle, one clock edge after that collision. No `tx_go` follows for that frame, even while `tx_req` stays high. The controller returns to idle only after `tx_req` falls.
- R7: With no-drop mode on, collisions beyond `ATTEMPT_LIMIT` never drop the frame. Each one is followed by a retry, with k bounded as in R4 or R5.
- R8: The collision count returns to zero when `tx_req` falls while the port is transmitting (success) and when a frame is dropped. The next frame therefore drops only at its own 16th collision.
- R9: A collision while `jam_active` is high makes `tx_go` pulse on the next clock edge, with no backoff and no gap. Such a collision does not add to the collision count.
- R10: One bit time is `FAST_DIV` clocks when `link_fast` is 1 and `SLOW_DIV` clocks when it is 0. Transitions out of the transmitting state are not held back by the bit tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_fast | input | 1 | 1: fast link divider, 0: slow link divider |
| carrier_sense | input | 1 | Medium busy |
| coll_pulse | input | 1 | Collision seen in this cycle |
| tx_req | input | 1 | Frame pending; lowered when the frame has completed |
| jam_active | input | 1 | Port is sending backpressure jam traffic |
| aggr_mode | input | 1 | Cap the backoff below 8 slots |
| two_part_mode | input | 1 | Watch carrier only in the first part of the gap |
| no_drop_mode | input | 1 | Never drop after the attempt limit |
| tx_go | output | 1 | One-cycle pulse: transmission may start |
| frame_drop | output | 1 | One-cycle pulse: frame abandoned |

## Verification
The bench builds the block with a 4-bit slot, a 12-bit gap split as 8 + 4, dividers of 1 and 3, and the default cap of 10 and limit of 16. The short slot makes the full exponential range up to 1023 slots, and all 16 collision levels of several frames, affordable in one run. It also keeps every backoff a clean multiple that the bench can decompose exactly. The fast divider of 1 makes gap timing exact to the edge, so the bench can sweep every carrier position across the gap in both deferral modes. The divider of 3 exercises the slow-speed rounding of bit ticks.

// File: rtl/hdx_backoff_pkg.sv
package hdx_backoff_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEFER,
      ST_BACKOFF,
      ST_XMIT,
      ST_HOLD
   } bo_state_t;

   // Galois feedback masks (right-shift form) for supported LFSR widths
   function automatic logic [31:0] galois_taps(input int unsigned w);
      case (w)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         24:      return 32'h00E1_0000;
         32:      return 32'hA300_0000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hdx_bit_tick.sv
module hdx_bit_tick #(
   parameter int unsigned FAST_DIV = 1,
   parameter int unsigned SLOW_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_fast,
   output logic bit_tick
);
   import hdx_backoff_pkg::*;

   localparam int unsigned MAXD = max_u(FAST_DIV, SLOW_DIV);
   localparam int unsigned DW   = (MAXD > 1) ? $clog2(MAXD) : 1;

   if (FAST_DIV < 1 || SLOW_DIV < 1) begin : g_bad_div
      $error("hdx_bit_tick: dividers must be at least 1");
   end

   logic [DW-1:0] div_cnt;
   logic [DW-1:0] div_lim;

   assign div_lim  = link_fast ? DW'(FAST_DIV - 1) : DW'(SLOW_DIV - 1);
   assign bit_tick = (div_cnt >= div_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_cnt <= '0;
      else if (bit_tick) div_cnt <= '0;
      else               div_cnt <= div_cnt + 1'b1;
   end

endmodule

// File: rtl/hdx_lfsr.sv
module hdx_lfsr #(
   parameter int unsigned W     = 16,
   parameter int unsigned OUT_W = 10,
   parameter logic [W-1:0] SEED = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);
   import hdx_backoff_pkg::*;

   localparam logic [31:0]  TAPS_ALL = galois_taps(W);
   localparam logic [W-1:0] TAPS     = TAPS_ALL[W-1:0];

   if (TAPS_ALL == 32'h0) begin : g_bad_width
      $error("hdx_lfsr: unsupported width");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("hdx_lfsr: seed must be nonzero");
   end
   if (OUT_W > W) begin : g_bad_out
      $error("hdx_lfsr: output wider than register");
   end

   logic [W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SEED;
      else        st <= {1'b0, st[W-1:1]} ^ (st[0] ? TAPS : '0);
   end

   assign rnd = st[OUT_W-1:0];

endmodule

// File: rtl/hdx_slot_draw.sv
module hdx_slot_draw #(
   parameter int unsigned KW        = 10,
   parameter int unsigned CW        = 5,
   parameter int unsigned CAP       = 10,
   parameter int unsigned AGGR_BITS = 3
) (
   input  logic [KW-1:0] rnd,
   input  logic [CW-1:0] coll_n,
   input  logic          aggr,
   output logic [KW-1:0] slots
);
   logic [KW-1:0] mask;

   for (genvar i = 0; i < KW; i++) begin : g_mask
      // standard: bit i kept when i < min(n, CAP); aggressive: low bits only
      assign mask[i] = aggr ? (i < AGGR_BITS)
                            : ((i < CAP) && (int'(coll_n) > i));
   end

   assign slots = rnd & mask;

endmodule

// File: rtl/hdx_backoff_ctrl.sv
module hdx_backoff_ctrl #(
   parameter int unsigned SLOT_BITS     = 512,
   parameter int unsigned IFG_BITS      = 96,
   parameter int unsigned IFG_PART1     = 64,
   parameter int unsigned ATTEMPT_LIMIT = 16,
   parameter int unsigned BACKOFF_CAP   = 10,
   parameter int unsigned AGGR_BITS     = 3,
   parameter int unsigned LFSR_W        = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   parameter int unsigned FAST_DIV      = 1,
   parameter int unsigned SLOW_DIV      = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_fast,
   input  logic carrier_sense,
   input  logic coll_pulse,
   input  logic tx_req,
   input  logic jam_active,
   input  logic aggr_mode,
   input  logic two_part_mode,
   input  logic no_drop_mode,
   output logic tx_go,
   output logic frame_drop
);
   import hdx_backoff_pkg::*;

   localparam int unsigned KW  = max_u(BACKOFF_CAP, AGGR_BITS);
   localparam int unsigned CW  = max_u($clog2(ATTEMPT_LIMIT + 1), $clog2(BACKOFF_CAP + 1));
   localparam int unsigned SBW = $clog2(SLOT_BITS);
   localparam int unsigned IW  = $clog2(IFG_BITS);

   if (SLOT_BITS < 2) begin : g_bad_slot
      $error("hdx_backoff_ctrl: SLOT_BITS must be at least 2");
   end
   if (IFG_BITS < 2 || IFG_PART1 >= IFG_BITS) begin : g_bad_ifg
      $error("hdx_backoff_ctrl: IFG_PART1 must be below IFG_BITS");
   end
   if (ATTEMPT_LIMIT < 1) begin : g_bad_limit
      $error("hdx_backoff_ctrl: ATTEMPT_LIMIT must be at least 1");
   end
   if (KW > LFSR_W) begin : g_bad_rng
      $error("hdx_backoff_ctrl: LFSR narrower than the backoff draw");
   end

   bo_state_t      state;
   logic           bit_tick;
   logic [KW-1:0]  rnd;
   logic [KW-1:0]  draw_slots;
   logic [CW-1:0]  coll_cnt;
   logic [CW-1:0]  n_next;
   logic [IW-1:0]  ifg_cnt;
   logic [SBW-1:0] bit_cnt;
   logic [KW-1:0]  slots_left;
   logic           restart;
   logic           hit_limit;

   hdx_bit_tick #(
      .FAST_DIV (FAST_DIV),
      .SLOW_DIV (SLOW_DIV)
   ) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_fast (link_fast),
      .bit_tick  (bit_tick)
   );

   hdx_lfsr #(
      .W     (LFSR_W),
      .OUT_W (KW),
      .SEED  (LFSR_SEED)
   ) u_rng (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   hdx_slot_draw #(
      .KW        (KW),
      .CW        (CW),
      .CAP       (BACKOFF_CAP),
      .AGGR_BITS (AGGR_BITS)
   ) u_draw (
      .rnd    (rnd),
      .coll_n (n_next),
      .aggr   (aggr_mode),
      .slots  (draw_slots)
   );

   // saturating count of this collision, used for the draw and the limit
   assign n_next    = (coll_cnt == '1) ? coll_cnt : coll_cnt + 1'b1;
   assign hit_limit = !no_drop_mode && (n_next >= CW'(ATTEMPT_LIMIT));
   assign restart   = carrier_sense &&
                      (!two_part_mode || (ifg_cnt < IW'(IFG_PART1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         coll_cnt   <= '0;
         ifg_cnt    <= '0;
         bit_cnt    <= '0;
         slots_left <= '0;
         tx_go      <= 1'b0;
         frame_drop <= 1'b0;
      end else begin
         tx_go      <= 1'b0;
         frame_drop <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (tx_req) begin
                  state   <= ST_DEFER;
                  ifg_cnt <= '0;
               end
            end
            ST_DEFER: begin
               if (bit_tick) begin
                  if (restart) begin
                     ifg_cnt <= '0;
                  end else if (ifg_cnt == IW'(IFG_BITS - 1)) begin
                     state <= ST_XMIT;
                     tx_go <= 1'b1;
                  end else begin
                     ifg_cnt <= ifg_cnt + 1'b1;
                  end
               end
            end
            ST_BACKOFF: begin
               if (bit_tick) begin
                  if (bit_cnt == SBW'(SLOT_BITS - 1)) begin
                     bit_cnt <= '0;
                     if (slots_left == KW'(1)) begin
                        state   <= ST_DEFER;
                        ifg_cnt <= '0;
                     end else begin
                        slots_left <= slots_left - 1'b1;
                     end
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_XMIT: begin
               if (!tx_req) begin
                  coll_cnt <= '0;
                  state    <= ST_IDLE;
               end else if (coll_pulse) begin
                  if (jam_active) begin
                     tx_go <= 1'b1;
                  end else if (hit_limit) begin
                     frame_drop <= 1'b1;
                     coll_cnt   <= '0;
                     state      <= ST_HOLD;
                  end else begin
                     coll_cnt <= n_next;
                     if (draw_slots == '0) begin
                        state   <= ST_DEFER;
                        ifg_cnt <= '0;
                     end else begin
                        state      <= ST_BACKOFF;
                        slots_left <= draw_slots;
                        bit_cnt    <= '0;
                     end
                  end
               end
            end
            ST_HOLD: begin
               if (!tx_req) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hdx_backoff_chk.sv
module hdx_backoff_chk #(
   parameter int unsigned KW        = 10,
   parameter int unsigned AGGR_BITS = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       tx_req,
   input logic                       coll_pulse,
   input logic                       jam_active,
   input logic                       aggr_mode,
   input logic                       tx_go,
   input logic                       frame_drop,
   input hdx_backoff_pkg::bo_state_t state_q,
   input logic [KW-1:0]              draw_slots
);
   import hdx_backoff_pkg::*;

   // R1: first cycle out of reset is quiet
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!tx_go && !frame_drop));

   // R2: a start pulse comes only from the gap or from a jam restart
   a_r2_go_source: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |-> ($past(state_q) == ST_DEFER) ||
                ($past(state_q) == ST_XMIT && $past(jam_active)));

   // R5: aggressive draw stays below 2^AGGR_BITS slots
   a_r5_aggr_cap: assert property (@(posedge clk) disable iff (!rst_n)
      aggr_mode |-> ((draw_slots >> AGGR_BITS) == '0));

   // R6: a drop follows a collision and never coincides with a start
   a_r6_drop_after_coll: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop |-> ($past(coll_pulse) && !tx_go));

   // R6: the drop is a single-cycle pulse
   a_r6_drop_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop |=> !frame_drop);

   // R9: a collision during jam restarts at the next edge
   a_r9_jam_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_XMIT && tx_req && coll_pulse && jam_active) |=> (tx_go && !frame_drop));

endmodule

bind hdx_backoff_ctrl hdx_backoff_chk #(
   .KW        (KW),
   .AGGR_BITS (AGGR_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_req     (tx_req),
   .coll_pulse (coll_pulse),
   .jam_active (jam_active),
   .aggr_mode  (aggr_mode),
   .tx_go      (tx_go),
   .frame_drop (frame_drop),
   .state_q    (state),
   .draw_slots (draw_slots)
);

// File: tb/test_hdx_backoff_ctrl.sv
`timescale 1ns/1ps
module test_hdx_backoff_ctrl;

   localparam int S    = 4;
   localparam int IFG  = 12;
   localparam int P1   = 8;
   localparam int DIVS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_fast = 1'b1;
   logic crs = 1'b0;
   logic coll = 1'b0;
   logic tx_req = 1'b0;
   logic jam = 1'b0;
   logic aggr = 1'b0;
   logic two_part = 1'b0;
   logic no_drop = 1'b0;
   logic tx_go;
   logic frame_drop;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   hdx_backoff_ctrl #(
      .SLOT_BITS     (S),
      .IFG_BITS      (IFG),
      .IFG_PART1     (P1),
      .ATTEMPT_LIMIT (16),
      .BACKOFF_CAP   (10),
      .FAST_DIV      (1),
      .SLOW_DIV      (DIVS)
   ) i_hdx_backoff_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .link_fast     (link_fast),
      .carrier_sense (crs),
      .coll_pulse    (coll),
      .tx_req        (tx_req),
      .jam_active    (jam),
      .aggr_mode     (aggr),
      .two_part_mode (two_part),
      .no_drop_mode  (no_drop),
      .tx_go         (tx_go),
      .frame_drop    (frame_drop)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // counts edges from the first edge (index 0) to the edge whose result shows tx_go or frame_drop
   task automatic wait_event(input int crs_at, output int d, output bit go, output bit dr);
      bit done = 1'b0;
      int e = 0;
      d = -1; go = 1'b0; dr = 1'b0;
      while (!done && e < 20000) begin
         @(posedge clk);
         @(negedge clk);
         coll = 1'b0;
         if (tx_go || frame_drop) begin
            done = 1'b1; d = e; go = tx_go; dr = frame_drop;
         end else begin
            e++;
            crs = (e == crs_at);
         end
      end
      crs = 1'b0;
   endtask

   task automatic start_frame(input int crs_at, input int exp_d, input string tag);
      int d; bit go; bit dr;
      tx_req = 1'b1;
      wait_event(crs_at, d, go, dr);
      check(go && !dr && d == exp_d, tag, d, exp_d);
   endtask

   task automatic end_frame();
      tx_req = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   // collision n of the frame; checks the retry delay decomposes into k slots plus the gap
   task automatic retry(input int n, input bit cap8, input int div, input string tag);
      int d; bit go; bit dr; int t; int lim; int k;
      coll = 1'b1;
      wait_event(0, d, go, dr);
      t   = (d + div - 1) / div;
      lim = cap8 ? 7 : (1 << ((n < 10) ? n : 10)) - 1;
      k   = (t - IFG) / S;
      check(go && !dr && t >= IFG && ((t - IFG) % S) == 0 && k <= lim, tag, k, lim);
   endtask

   task automatic expect_drop(input string tag);
      int d; bit go; bit dr; int stray;
      coll = 1'b1;
      wait_event(0, d, go, dr);
      check(dr && !go && d == 0, tag, d, 0);
      stray = 0;
      for (int i = 0; i < 40; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (tx_go || frame_drop) stray++;
      end
      check(stray == 0, tag, stray, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(190000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int stray;
      // R1: reset state
      repeat (4) @(negedge clk);
      check(!tx_go && !frame_drop, "R1 in reset", tx_go, 0);
      rst_n = 1'b1;
      stray = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (tx_go || frame_drop) stray++;
      end
      check(stray == 0, "R1 idle after reset", stray, 0);

      // R2: plain gap, then carrier at every position in standard mode
      start_frame(0, IFG, "R2 plain gap");
      end_frame();
      for (int c = 1; c <= IFG; c++) begin
         start_frame(c, c + IFG, "R2 carrier restart");
         end_frame();
      end

      // R3: two-part gap, carrier at every position
      two_part = 1'b1;
      for (int c = 1; c <= IFG; c++) begin
         start_frame(c, (c <= P1) ? c + IFG : IFG, "R3 two-part gap");
         end_frame();
      end
      two_part = 1'b0;

      // R4 then R8: success clears the count
      start_frame(0, IFG, "R2 frame start");
      for (int n = 1; n <= 3; n++) retry(n, 1'b0, 1, "R4 standard range");
      end_frame();

      // R4, R6: full frame to the limit
      start_frame(0, IFG, "R2 frame start");
      for (int n = 1; n <= 15; n++) retry(n, 1'b0, 1, "R4 standard range");
      expect_drop("R6 drop at limit");
      end_frame();

      // R8: after a drop the next frame again drops at its own 16th collision
      start_frame(0, IFG, "R2 frame start");
      for (int n = 1; n <= 15; n++) retry(n, 1'b0, 1, "R8 count cleared");
      expect_drop("R8 drop after clear");
      end_frame();

      // R7: no-drop mode keeps retrying past the limit
      no_drop = 1'b1;
      start_frame(0, IFG, "R2 frame start");
      for (int n = 1; n <= 18; n++) retry(n, 1'b0, 1, "R7 no drop");
      end_frame();
      no_drop = 1'b0;

      // R5: aggressive mode stays below 8 slots and still drops at 16
      aggr = 1'b1;
      start_frame(0, IFG, "R2 frame start");
      for (int n = 1; n <= 15; n++) retry(n, 1'b1, 1, "R5 aggressive cap");
      expect_drop("R5 aggressive drop");
      end_frame();
      aggr = 1'b0;

      // R9: jam collisions restart at once and are not counted
      start_frame(0, IFG, "R2 frame start");
      jam = 1'b1;
      for (int n = 1; n <= 20; n++) begin
         int d; bit go; bit dr;
         coll = 1'b1;
         wait_event(0, d, go, dr);
         check(go && !dr && d == 0, "R9 jam restart", d, 0);
      end
      jam = 1'b0;
      retry(1, 1'b0, 1, "R9 jam not counted");
      end_frame();

      // R10: slow link divider
      link_fast = 1'b0;
      begin
         int d; bit go; bit dr;
         tx_req = 1'b1;
         wait_event(0, d, go, dr);
         check(go && !dr && (d + DIVS - 1) / DIVS == IFG, "R10 slow gap", (d + DIVS - 1) / DIVS, IFG);
      end
      retry(1, 1'b0, DIVS, "R10 slow backoff");
      end_frame();
      link_fast = 1'b1;

      finish_run();
   end

endmodule